// File: doc/BRIEF.md
# Three-Channel Output Precision Limiter

This stage takes three wide two's-complement results and narrows each one to a shorter signed word. Every channel has its own pair of run-time counts. One count says how many bits to strip from the top of the word. The other says how many to strip from the bottom. Every channel also has its own two mode bits. At the top end, a channel either clamps its value into the new range or drops the upper bits so the value wraps. At the bottom end, it either rounds to nearest with halves going up, or it simply discards the low bits.

A single full-precision bypass input passes all three inputs through untouched. The stage is registered: a result is loaded only in a cycle where the input valid is high, and the output valid repeats the input valid one clock later. A synchronous, active-high clear empties the stage.

Each narrowed result is right-aligned in its channel's output lane and sign-extended to the full lane width. A downstream block can therefore use either the low bits alone or the whole lane.

Top module: `prec_limiter`

## Requirements
- R1: `outValid` equals the value `inValid` had one clock earlier. `outData` takes a new result only at a rising edge where `inValid` is high, so the latency is exactly one clock.
- R2: When `clr` is high at a rising edge, `outValid` and all of `outData` become 0 at that edge. This happens even if `inValid` is also high.
- R3: While `inValid` is low, `outData` holds its last value whatever the data and settings inputs do.
- R4: When `bypass` is high, each output lane equals its input lane exactly. The counts and mode bits have no effect.
- R5: With the round bit of channel k at 0, the L low bits are discarded by an arithmetic right shift. This rounds toward minus infinity (for example, -9 with L=4 gives -1).
- R6: With the round bit at 1 and L>0, the value 2^(L-1) is added before the shift, so exact halves go toward plus infinity. With L=0 the round bit has no effect.
- R7: With the saturate bit of channel k at 1, a value outside the signed range of K = W-M-L bits becomes 2^(K-1)-1 or -2^(K-1).
- R8: With the saturate bit at 0, only the low K bits of the shifted value are kept, sign-extended from bit K-1. The value wraps modulo 2^K.
- R9: Rounding is done before the range check. A round-up that carries past the top of K bits is therefore clamped when saturation is on, and wraps when it is off.
- R10: Each channel uses only its own lane of `inData`, its own counts and its own mode bits. A change in one channel never alters the result of another.
- R11: Channel k occupies bits [k*W +: W] of `inData`, `outData`, and occupies bits [k*CW +: CW] of `msbDrop` and `lsbDrop`. It also uses bit k of `satMode` (1 = clamp) and of `rndMode` (1 = round). The narrowed result is sign-extended to W bits. Counts must satisfy M+L <= W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high clear |
| inValid | input | 1 | A result is present on `inData` |
| bypass | input | 1 | Full-precision pass-through for all channels |
| satMode | input | NCH | Per channel: 1 clamps, 0 wraps at the top |
| rndMode | input | NCH | Per channel: 1 rounds, 0 truncates at the bottom |
| msbDrop | input | NCH*CW | Per-channel count of top bits removed |
| lsbDrop | input | NCH*CW | Per-channel count of bottom bits removed |
| inData | input | NCH*W | Wide two's-complement results, channel 0 lowest |
| outValid | output | 1 | `outData` holds a fresh result |
| outData | output | NCH*W | Narrowed results, sign-extended per lane |

## Verification
The width assertion assumes that each channel's two counts sum to at most W-1 whenever a result is captured. Without that, the kept width would be zero or negative and no range exists to check against. The stimulus keeps within this limit: every directed case uses counts chosen by hand, and the sweep draws the bottom count from what remains after the top count has been chosen. Changes made to the inputs while `inValid` is low are also kept within these legal ranges, so the hold checks compare against captured values that are well defined.

// File: rtl/prec_limiter_pkg.sv
package prec_limiter_pkg;

  // Strobes handed from the control module to the datapath.
  typedef struct packed {
    logic capture;  // load a new result this edge
    logic wipe;     // clear the result registers this edge
  } stageCtrlT;

endpackage

// File: rtl/prec_limiter_lane.sv
// Combinational narrowing of one channel: optional round, arithmetic shift,
// then clamp or wrap to the kept width, sign-extended back to W bits.
module prec_limiter_lane #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] msbCnt,
  input  logic [CW-1:0] lsbCnt,
  input  logic          satEn,
  input  logic          rndEn,
  output logic [W-1:0]  dout
);
  localparam int EW = W + 1;

  logic signed [W:0] extVal;
  logic signed [W:0] rndVal;
  logic signed [W:0] shfVal;
  logic signed [W:0] maxVal;
  logic signed [W:0] minVal;
  logic [CW:0]       keepW;
  logic [W-1:0]      wrapVal;
  logic              overHi;
  logic              overLo;

  always_comb begin
    // Kept width K = W - M - L.
    keepW  = (CW+1)'(W) - (CW+1)'(msbCnt) - (CW+1)'(lsbCnt);
    extVal = {din[W-1], din};
    rndVal = extVal;
    // The rounding bias is added before any range decision (R9).
    if (rndEn && (lsbCnt != '0)) begin
      rndVal = extVal + (EW'(1) << (lsbCnt - 1'b1));
    end
    shfVal = rndVal >>> lsbCnt;
    maxVal = (EW'(1) << (keepW - 1'b1)) - EW'(1);
    minVal = ~maxVal;
    overHi = shfVal > maxVal;
    overLo = shfVal < minVal;
    for (int i = 0; i < W; i++) begin
      if (i < int'(keepW)) wrapVal[i] = shfVal[i];
      else                 wrapVal[i] = shfVal[keepW - 1'b1];
    end
    if (satEn && overHi)      dout = maxVal[W-1:0];
    else if (satEn && overLo) dout = minVal[W-1:0];
    else                      dout = wrapVal;
  end

endmodule

// File: rtl/prec_limiter_ctrl.sv
// Valid pipeline and strobe generation.
module prec_limiter_ctrl
  import prec_limiter_pkg::*;
(
  input  logic      clk,
  input  logic      clr,
  input  logic      inValid,
  output stageCtrlT stb,
  output logic      outValid
);

  always_comb begin
    stb.wipe    = clr;
    stb.capture = inValid & ~clr;
  end

  always_ff @(posedge clk) begin
    if (clr) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (clr)
    inValid |=> outValid);
  // R1
  valid_low_chk: assert property (@(posedge clk) disable iff (clr)
    !inValid |=> !outValid);
  // R2
  clear_valid_chk: assert property (@(posedge clk)
    clr |=> !outValid);

endmodule

// File: rtl/prec_limiter_dp.sv
// Per-channel lanes plus the result register bank and bypass selection.
module prec_limiter_dp
  import prec_limiter_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3,
  parameter int CW  = $clog2(W)
) (
  input  logic              clk,
  input  stageCtrlT         stb,
  input  logic              bypass,
  input  logic [NCH-1:0]    satMode,
  input  logic [NCH-1:0]    rndMode,
  input  logic [NCH*CW-1:0] msbDrop,
  input  logic [NCH*CW-1:0] lsbDrop,
  input  logic [NCH*W-1:0]  inData,
  output logic [NCH*W-1:0]  outData
);

  logic [NCH*W-1:0] laneOut;
  logic [NCH*W-1:0] nextData;

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    prec_limiter_lane #(.W(W), .CW(CW)) lane_i (
      .din    (inData[k*W +: W]),
      .msbCnt (msbDrop[k*CW +: CW]),
      .lsbCnt (lsbDrop[k*CW +: CW]),
      .satEn  (satMode[k]),
      .rndEn  (rndMode[k]),
      .dout   (laneOut[k*W +: W])
    );
  end

  assign nextData = bypass ? inData : laneOut;

  always_ff @(posedge clk) begin
    if (stb.wipe)         outData <= '0;
    else if (stb.capture) outData <= nextData;
  end

  function automatic int keepOf(input logic [CW-1:0] m, input logic [CW-1:0] l);
    return W - int'(m) - int'(l);
  endfunction

  function automatic logic fitsKeep(input logic [W-1:0] v, input int keep);
    for (int i = 0; i < W; i++) begin
      if (i >= keep - 1 && keep >= 1 && v[i] != v[keep-1]) return 1'b0;
    end
    return 1'b1;
  endfunction

  // R2
  clear_data_chk: assert property (@(posedge clk)
    stb.wipe |=> outData == '0);
  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (stb.wipe)
    !stb.capture |=> $stable(outData));
  // R4
  bypass_pass_chk: assert property (@(posedge clk) disable iff (stb.wipe)
    stb.capture && bypass |=> outData == $past(inData));

  for (genvar k = 0; k < NCH; k++) begin : g_fit
    // R11
    width_fit_chk: assert property (@(posedge clk) disable iff (stb.wipe)
      stb.capture && !bypass |=>
        fitsKeep(outData[k*W +: W],
                 keepOf($past(msbDrop[k*CW +: CW]), $past(lsbDrop[k*CW +: CW]))));
  end

endmodule

// File: rtl/prec_limiter.sv
module prec_limiter
  import prec_limiter_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3,
  localparam int CW = $clog2(W)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              inValid,
  input  logic              bypass,
  input  logic [NCH-1:0]    satMode,
  input  logic [NCH-1:0]    rndMode,
  input  logic [NCH*CW-1:0] msbDrop,
  input  logic [NCH*CW-1:0] lsbDrop,
  input  logic [NCH*W-1:0]  inData,
  output logic              outValid,
  output logic [NCH*W-1:0]  outData
);

  stageCtrlT stb;

  prec_limiter_ctrl ctrl_i (
    .clk      (clk),
    .clr      (clr),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  prec_limiter_dp #(.W(W), .NCH(NCH), .CW(CW)) dp_i (
    .clk     (clk),
    .stb     (stb),
    .bypass  (bypass),
    .satMode (satMode),
    .rndMode (rndMode),
    .msbDrop (msbDrop),
    .lsbDrop (lsbDrop),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: tb/prec_limiter_tb_top.sv
`timescale 1ns/1ps
module prec_limiter_tb_top;
  localparam int W   = 16;
  localparam int NCH = 3;
  localparam int CW  = 4;

  logic              clk = 1'b0;
  logic              clr;
  logic              inValid;
  logic              bypass;
  logic [NCH-1:0]    satMode;
  logic [NCH-1:0]    rndMode;
  logic [NCH*CW-1:0] msbDrop;
  logic [NCH*CW-1:0] lsbDrop;
  logic [NCH*W-1:0]  inData;
  logic              outValid;
  logic [NCH*W-1:0]  outData;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  prec_limiter dut_i (
    .clk(clk), .clr(clr), .inValid(inValid), .bypass(bypass),
    .satMode(satMode), .rndMode(rndMode), .msbDrop(msbDrop),
    .lsbDrop(lsbDrop), .inData(inData), .outValid(outValid),
    .outData(outData)
  );

  // Reference narrowing written from the requirements.
  function automatic logic [W-1:0] model(input logic [W-1:0] x, input int m,
                                         input int l, input bit sat, input bit rnd);
    longint v, hi, lo, span;
    int keep;
    v = longint'($signed(x));
    if (rnd && l > 0) v = v + (longint'(1) << (l - 1));
    v = v >>> l;
    keep = W - m - l;
    span = longint'(1) << keep;
    hi = (longint'(1) << (keep - 1)) - 1;
    lo = -(longint'(1) << (keep - 1));
    if (sat) begin
      if (v > hi) v = hi;
      else if (v < lo) v = lo;
    end else begin
      v = v & (span - 1);
      if (v > hi) v = v - span;
    end
    return v[W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setCh(input int k, input logic [W-1:0] x, input int m, input int l,
                       input bit sat, input bit rnd);
    inData[k*W +: W]   = x;
    msbDrop[k*CW +: CW] = CW'(m);
    lsbDrop[k*CW +: CW] = CW'(l);
    satMode[k] = sat;
    rndMode[k] = rnd;
  endtask

  // Apply the channel settings for one cycle and compare each lane with the model.
  task automatic runAndCheck(input string req);
    logic [NCH*W-1:0] exp;
    for (int k = 0; k < NCH; k++) begin
      exp[k*W +: W] = model(inData[k*W +: W], int'(msbDrop[k*CW +: CW]),
                            int'(lsbDrop[k*CW +: CW]), satMode[k], rndMode[k]);
    end
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, req, outValid, 1);
    for (int k = 0; k < NCH; k++) begin
      check(outData[k*W +: W] == exp[k*W +: W], req,
            outData[k*W +: W], exp[k*W +: W]);
    end
  endtask

  task automatic testReset();
    clr = 1'b1; inValid = 1'b1; bypass = 1'b0;
    for (int k = 0; k < NCH; k++) setCh(k, 16'h1234, 0, 0, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    // R2: clear wins over a valid input
    check(outValid == 1'b0, "R2", outValid, 0);
    check(outData == '0, "R2", outData, 0);
    clr = 1'b0; inValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic testTruncate();
    // R5: floor shift, also negative values
    setCh(0, 16'h1234, 4, 4, 1'b0, 1'b0);
    setCh(1, 16'hFFF7, 0, 4, 1'b0, 1'b0);
    setCh(2, 16'hF0F7, 4, 4, 1'b1, 1'b0);
    runAndCheck("R5");
    check(outData[W +: W] == 16'hFFFF, "R5", outData[W +: W], 16'hFFFF);
  endtask

  task automatic testRound();
    // R6: half up, below half down, negative half toward +inf, L=0 no effect
    setCh(0, 16'h0008, 0, 4, 1'b1, 1'b1);
    setCh(1, 16'h0007, 0, 4, 1'b1, 1'b1);
    setCh(2, 16'hFFF8, 0, 4, 1'b1, 1'b1);
    runAndCheck("R6");
    check(outData[0 +: W] == 16'h0001, "R6", outData[0 +: W], 1);
    check(outData[2*W +: W] == 16'h0000, "R6", outData[2*W +: W], 0);
    setCh(0, 16'h8123, 0, 0, 1'b0, 1'b1);
    runAndCheck("R6");
    check(outData[0 +: W] == 16'h8123, "R6", outData[0 +: W], 16'h8123);
  endtask

  task automatic testSaturate();
    // R7: K=12 clamps to 0x07FF / 0xF800
    setCh(0, 16'h7000, 4, 0, 1'b1, 1'b0);
    setCh(1, 16'h8000, 4, 0, 1'b1, 1'b0);
    setCh(2, 16'h0123, 4, 0, 1'b1, 1'b0);
    runAndCheck("R7");
    check(outData[0 +: W] == 16'h07FF, "R7", outData[0 +: W], 16'h07FF);
    check(outData[W +: W] == 16'hF800, "R7", outData[W +: W], 16'hF800);
  endtask

  task automatic testWrap();
    // R8: low K bits kept, sign-extended
    setCh(0, 16'h7000, 4, 0, 1'b0, 1'b0);
    setCh(1, 16'h0900, 4, 0, 1'b0, 1'b0);
    setCh(2, 16'h8ABC, 8, 0, 1'b0, 1'b0);
    runAndCheck("R8");
    check(outData[W +: W] == 16'hF900, "R8", outData[W +: W], 16'hF900);
  endtask

  task automatic testRoundIntoSat();
    // R9: 127.5 rounds to 128, which clamps to 127 or wraps to -128 (K=8)
    setCh(0, 16'h07F8, 4, 4, 1'b1, 1'b1);
    setCh(1, 16'h07F8, 4, 4, 1'b0, 1'b1);
    setCh(2, 16'hF808, 4, 4, 1'b1, 1'b1);
    runAndCheck("R9");
    check(outData[0 +: W] == 16'h007F, "R9", outData[0 +: W], 16'h007F);
    check(outData[W +: W] == 16'hFF80, "R9", outData[W +: W], 16'hFF80);
  endtask

  task automatic testBypass();
    // R4: settings ignored
    setCh(0, 16'h7FFF, 8, 4, 1'b1, 1'b1);
    setCh(1, 16'h8001, 3, 3, 1'b0, 1'b1);
    setCh(2, 16'h0F0F, 7, 8, 1'b1, 1'b0);
    bypass = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outData == 48'h0F0F_8001_7FFF, "R4", outData, 48'h0F0F_8001_7FFF);
    bypass = 1'b0;
  endtask

  task automatic testHoldAndValid();
    logic [NCH*W-1:0] kept;
    setCh(0, 16'h1111, 2, 2, 1'b1, 1'b0);
    setCh(1, 16'h2222, 2, 2, 1'b1, 1'b0);
    setCh(2, 16'h3333, 2, 2, 1'b1, 1'b0);
    runAndCheck("R1");
    kept = outData;
    // R1 and R3: no valid, changing inputs, output holds and valid drops
    setCh(0, 16'hAAAA, 0, 1, 1'b0, 1'b1);
    setCh(1, 16'h5555, 1, 0, 1'b0, 1'b0);
    bypass = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", outValid, 0);
    check(outData == kept, "R3", outData, kept);
    @(negedge clk);
    check(outData == kept, "R3", outData, kept);
    bypass = 1'b0;
  endtask

  task automatic testClearPriority();
    setCh(0, 16'h4444, 0, 0, 1'b0, 1'b0);
    clr = 1'b1; inValid = 1'b1;
    @(negedge clk);
    clr = 1'b0; inValid = 1'b0;
    // R2
    check(outValid == 1'b0, "R2", outValid, 0);
    check(outData == '0, "R2", outData, 0);
  endtask

  task automatic testIndependent();
    // R10: same input, different settings per channel
    setCh(0, 16'h6789, 3, 5, 1'b1, 1'b1);
    setCh(1, 16'h6789, 3, 5, 1'b0, 1'b0);
    setCh(2, 16'h6789, 0, 0, 1'b0, 1'b0);
    runAndCheck("R10");
    check(outData[2*W +: W] == 16'h6789, "R10", outData[2*W +: W], 16'h6789);
  endtask

  task automatic testSweep();
    // R11: mixed random settings within M+L <= W-1
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < NCH; k++) begin
        int m, l;
        m = $urandom_range(0, W - 1);
        l = $urandom_range(0, W - 1 - m);
        setCh(k, 16'($urandom), m, l, 1'($urandom), 1'($urandom));
      end
      runAndCheck("R11");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    inData = '0; msbDrop = '0; lsbDrop = '0; satMode = '0; rndMode = '0;
    clr = 1'b1; inValid = 1'b0; bypass = 1'b0;
    @(negedge clk);
    testReset();
    testTruncate();
    testRound();
    testSaturate();
    testWrap();
    testRoundIntoSat();
    testBypass();
    testHoldAndValid();
    testClearPriority();
    testIndependent();
    testSweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule